// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block maps a physical page number (4 KiB pages) onto the chip-select row of a registered-DRAM memory controller that holds it. Software programs eight cumulative row boundary values, an attribute word that gives each row's device width, and a controller mode word that sets the boundary unit, the channel count and whether ECC is on. From these the block works out each row's page range, whether the row is populated, its device width and its ECC mode.

A decode strobe captures a page number. One cycle later the block presents the matching row index, a hit flag, the device width of that row and its ECC mode. It uses a small two-state machine: `ST_IDLE` (no fresh result) and `ST_REPORT` (a result is on the outputs with `out_valid` high). A strobe in either state moves to `ST_REPORT`. `ST_REPORT` with no strobe returns to `ST_IDLE`. The result fields hold their values until the next strobe.

The parameter `SINGLE_CH_CAPABLE` picks the controller variant. When it is 0, the block ignores the unit and channel fields of the mode word. That variant always uses a 64 MiB unit and always counts as dual-channel.

Top module: `row_boundary_decoder`

## Requirements
- R1: After reset all boundary values, the attribute word and the mode word are zero, and `out_valid` is low. A decode issued right after reset gives hit=0 and row_idx=0.
- R2: A write with `wr_en` high goes by `wr_addr`. Addresses 0 to 7 load row boundary 0 to 7 from `wr_data[7:0]`, with the upper data bits dropped. Address 8 loads the attribute word and address 9 loads the mode word. Every other address changes nothing.
- R3: If mode bits 19:18 are 00, one boundary unit is 32 MiB (8192 pages). If they hold any other value, one unit is 64 MiB (16384 pages). When `SINGLE_CH_CAPABLE`=0 the unit is always 64 MiB.
- R4: Row i covers pages from the end of row i-1 (row 0 starts at page 0) up to its own boundary times the unit, minus one.
- R5: A row whose boundary equals the previous row's boundary is unpopulated and never hits. Pages past it decode to the next populated row.
- R6: If several row ranges contain the page (boundaries not increasing), the lowest-index row is reported.
- R7: A page that no populated row covers, including any page at or above the last boundary, gives hit=0, row_idx=0, width_x4=0 and ecc_mode=0.
- R8: `width_x4` reports attribute bit 4*i+3 of the hit row: 0 means x8 devices, 1 means x4 devices.
- R9: `ecc_mode` is 0 (none) when mode bits 21:20 are 00. Otherwise it is 2 (4-bit symbol correction) for a row with x4 devices in dual-channel mode, and 1 (single-error-correct/double-error-detect) for every other row. Mode bit 22 selects dual channel (1) or single channel (0). When `SINGLE_CH_CAPABLE`=0 the controller always counts as dual-channel. The code 3 never appears.
- R10: `out_valid` is high in exactly the cycle after each cycle with `decode_go` high, and back-to-back strobes each give their own result. The result fields change only in the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register select: 0-7 boundaries, 8 attribute, 9 mode |
| wr_data | input | 32 | Write data |
| decode_go | input | 1 | Decode strobe, samples `page_in` |
| page_in | input | 22 | Physical page number to decode |
| out_valid | output | 1 | Result from the previous cycle's strobe |
| hit | output | 1 | A populated row contains the page |
| row_idx | output | 3 | Index of the matching row, 0 on a miss |
| width_x4 | output | 1 | Row uses x4 devices (0 means x8) |
| ecc_mode | output | 2 | 0 none, 1 SECDED, 2 4-bit symbol correction |

## Verification
The checker tests on every cycle that a strobe gives a result exactly one cycle later and that the result fields hold still without a strobe. It also checks that a miss always shows row 0 with no width and no ECC, that symbol correction only appears on an x4 row, and that the unused ECC code never appears. Only the bench scenarios can show that a given page lands in the right row. That covers the 32 and 64 MiB units, skipped unpopulated rows, lowest-index priority for overlapping ranges, the attribute bit position, the ECC choice from the channel count, writes to unused addresses, and the fixed-unit variant. Each of these needs a model of the programmed values.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
    typedef enum logic [1:0] {
        ECC_NONE   = 2'd0,
        ECC_SECDED = 2'd1,
        ECC_SYMBOL = 2'd2
    } ecc_mode_e;

    localparam int unsigned CFG_W       = 32;
    localparam int unsigned ADDR_ATTR   = 8;
    localparam int unsigned ADDR_MODE   = 9;
    localparam int unsigned MODE_UNIT_LO = 18;
    localparam int unsigned MODE_ECC_LO  = 20;
    localparam int unsigned MODE_DUAL    = 22;
    localparam int unsigned PAGE_SHIFT_32M = 13;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } dec_state_e;
endpackage

// File: rtl/rbd_regs.sv
module rbd_regs #(
    parameter int unsigned ROWS   = 8,
    parameter int unsigned BND_W  = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [rbd_pkg::CFG_W-1:0]     wr_data,
    output logic [ROWS-1:0][BND_W-1:0]    bnd_q,
    output logic [rbd_pkg::CFG_W-1:0]     attr_q,
    output logic [rbd_pkg::CFG_W-1:0]     mode_q
);
    import rbd_pkg::*;

    for (genvar i = 0; i < ROWS; i++) begin : g_bnd
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bnd_q[i] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(i))) begin
                bnd_q[i] <= wr_data[BND_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attr_q <= '0;
            mode_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(ADDR_ATTR)) attr_q <= wr_data;
            if (wr_addr == ADDR_W'(ADDR_MODE)) mode_q <= wr_data;
        end
    end
endmodule

// File: rtl/rbd_cfg.sv
module rbd_cfg #(
    parameter bit SINGLE_CH_CAPABLE = 1'b1
) (
    input  logic [rbd_pkg::CFG_W-1:0] mode_q,
    output logic                      unit_64m,
    output logic                      dual_ch,
    output logic                      ecc_on
);
    import rbd_pkg::*;

    logic unused_mode;
    assign unused_mode = ^mode_q;

    assign ecc_on = |mode_q[MODE_ECC_LO +: 2];

    if (SINGLE_CH_CAPABLE) begin : g_flex
        assign unit_64m = |mode_q[MODE_UNIT_LO +: 2];
        assign dual_ch  = mode_q[MODE_DUAL];
    end else begin : g_fixed
        assign unit_64m = 1'b1;
        assign dual_ch  = 1'b1;
    end
endmodule

// File: rtl/rbd_rows.sv
module rbd_rows #(
    parameter int unsigned ROWS   = 8,
    parameter int unsigned BND_W  = 8,
    parameter int unsigned PAGE_W = 22
) (
    input  logic [ROWS-1:0][BND_W-1:0] bnd_q,
    input  logic                       unit_64m,
    input  logic [PAGE_W-1:0]          page,
    output logic [ROWS-1:0]            populated,
    output logic [ROWS-1:0]            match
);
    import rbd_pkg::*;

    logic [ROWS:0][PAGE_W-1:0] edge_pg;
    assign edge_pg[0] = '0;

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        logic [PAGE_W-1:0] ext;
        assign ext = PAGE_W'(bnd_q[i]);
        assign edge_pg[i+1] = unit_64m ? (ext << (PAGE_SHIFT_32M + 1))
                                       : (ext << PAGE_SHIFT_32M);
        assign populated[i] = (edge_pg[i+1] != edge_pg[i]);
        assign match[i]     = populated[i]
                              && (page >= edge_pg[i])
                              && (page <  edge_pg[i+1]);
    end
endmodule

// File: rtl/rbd_attr.sv
module rbd_attr #(
    parameter int unsigned ROWS = 8
) (
    input  logic [rbd_pkg::CFG_W-1:0] attr_q,
    input  logic                      dual_ch,
    input  logic                      ecc_on,
    output logic [ROWS-1:0]           row_x4,
    output logic [ROWS-1:0][1:0]      row_ecc
);
    import rbd_pkg::*;

    logic unused_attr;
    assign unused_attr = ^attr_q;

    for (genvar i = 0; i < ROWS; i++) begin : g_attr
        assign row_x4[i] = attr_q[4*i+3];
        always_comb begin
            if (!ecc_on)                  row_ecc[i] = ECC_NONE;
            else if (dual_ch && row_x4[i]) row_ecc[i] = ECC_SYMBOL;
            else                          row_ecc[i] = ECC_SECDED;
        end
    end
endmodule

// File: rtl/row_boundary_decoder.sv
module row_boundary_decoder #(
    parameter int unsigned ROWS              = 8,
    parameter int unsigned BND_W             = 8,
    parameter int unsigned ADDR_W            = 4,
    parameter bit          SINGLE_CH_CAPABLE = 1'b1,
    localparam int unsigned ROW_W  = $clog2(ROWS),
    localparam int unsigned PAGE_W = BND_W + rbd_pkg::PAGE_SHIFT_32M + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [rbd_pkg::CFG_W-1:0] wr_data,
    input  logic                      decode_go,
    input  logic [PAGE_W-1:0]         page_in,
    output logic                      out_valid,
    output logic                      hit,
    output logic [ROW_W-1:0]          row_idx,
    output logic                      width_x4,
    output logic [1:0]                ecc_mode
);
    import rbd_pkg::*;

    logic [ROWS-1:0][BND_W-1:0] bnd_q;
    logic [CFG_W-1:0]           attr_q;
    logic [CFG_W-1:0]           mode_q;
    logic                       unit_64m;
    logic                       dual_ch;
    logic                       ecc_on;
    logic [ROWS-1:0]            populated;
    logic [ROWS-1:0]            match;
    logic [ROWS-1:0]            row_x4;
    logic [ROWS-1:0][1:0]       row_ecc;

    rbd_regs #(.ROWS(ROWS), .BND_W(BND_W), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .bnd_q  (bnd_q),
        .attr_q (attr_q),
        .mode_q (mode_q)
    );

    rbd_cfg #(.SINGLE_CH_CAPABLE(SINGLE_CH_CAPABLE)) u_cfg (
        .mode_q  (mode_q),
        .unit_64m(unit_64m),
        .dual_ch (dual_ch),
        .ecc_on  (ecc_on)
    );

    rbd_rows #(.ROWS(ROWS), .BND_W(BND_W), .PAGE_W(PAGE_W)) u_rows (
        .bnd_q    (bnd_q),
        .unit_64m (unit_64m),
        .page     (page_in),
        .populated(populated),
        .match    (match)
    );

    rbd_attr #(.ROWS(ROWS)) u_attr (
        .attr_q (attr_q),
        .dual_ch(dual_ch),
        .ecc_on (ecc_on),
        .row_x4 (row_x4),
        .row_ecc(row_ecc)
    );

    logic unused_pop;
    assign unused_pop = ^populated;

    // lowest-index match wins: scan from the top so lower rows overwrite
    logic             sel_hit;
    logic [ROW_W-1:0] sel_row;
    always_comb begin
        sel_hit = 1'b0;
        sel_row = '0;
        for (int i = ROWS - 1; i >= 0; i--) begin
            if (match[i]) begin
                sel_hit = 1'b1;
                sel_row = ROW_W'(i);
            end
        end
    end

    dec_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (decode_go) state_d = ST_REPORT;
            ST_REPORT: state_d = decode_go ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit      <= 1'b0;
            row_idx  <= '0;
            width_x4 <= 1'b0;
            ecc_mode <= ECC_NONE;
        end else if (decode_go) begin
            hit      <= sel_hit;
            row_idx  <= sel_row;
            width_x4 <= sel_hit ? row_x4[sel_row] : 1'b0;
            ecc_mode <= sel_hit ? row_ecc[sel_row] : ECC_NONE;
        end
    end

    assign out_valid = (state_q == ST_REPORT);
endmodule

// File: rtl/rbd_checker.sv
module rbd_checker #(
    parameter int unsigned ROW_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             decode_go,
    input logic             out_valid,
    input logic             hit,
    input logic [ROW_W-1:0] row_idx,
    input logic             width_x4,
    input logic [1:0]       ecc_mode
);
    assert_strobe_reports_R10: assert property (@(posedge clk) disable iff (!rst_n)
        decode_go |=> out_valid);

    assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !decode_go |=> !out_valid);

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !decode_go |=> $stable({hit, row_idx, width_x4, ecc_mode}));

    assert_miss_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !hit) |-> (row_idx == '0 && !width_x4 && ecc_mode == 2'd0));

    assert_symbol_on_x4_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ecc_mode == 2'd2) |-> width_x4);

    assert_ecc_code_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_mode != 2'd3);
endmodule

bind row_boundary_decoder rbd_checker #(.ROW_W(ROW_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .decode_go(decode_go),
    .out_valid(out_valid),
    .hit      (hit),
    .row_idx  (row_idx),
    .width_x4 (width_x4),
    .ecc_mode (ecc_mode)
);

// File: tb/row_boundary_decoder_tb.sv
module row_boundary_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        decode_go = 1'b0;
    logic [21:0] page_in = '0;

    logic        out_valid, hit, width_x4;
    logic [2:0]  row_idx;
    logic [1:0]  ecc_mode;
    logic        out_valid_f, hit_f, width_x4_f;
    logic [2:0]  row_idx_f;
    logic [1:0]  ecc_mode_f;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0]  sh_bnd [8];
    logic [31:0] sh_attr = '0;
    logic [31:0] sh_mode = '0;

    always #5 clk = ~clk;

    row_boundary_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .decode_go(decode_go), .page_in(page_in),
        .out_valid(out_valid), .hit(hit), .row_idx(row_idx),
        .width_x4(width_x4), .ecc_mode(ecc_mode)
    );

    row_boundary_decoder #(.SINGLE_CH_CAPABLE(1'b0)) u_dut_fix (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .decode_go(decode_go), .page_in(page_in),
        .out_valid(out_valid_f), .hit(hit_f), .row_idx(row_idx_f),
        .width_x4(width_x4_f), .ecc_mode(ecc_mode_f)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // result packing: {hit, row[2:0], x4, ecc[1:0]}
    function automatic logic [6:0] model(input logic [21:0] pg, input bit fixed);
        logic [21:0] lo = '0;
        logic [21:0] hi;
        logic        u64 = fixed ? 1'b1 : (sh_mode[19:18] != 2'b00);
        logic        dual = fixed ? 1'b1 : sh_mode[22];
        logic        en = (sh_mode[21:20] != 2'b00);
        logic [6:0]  res = '0;
        bit          found = 1'b0;
        for (int i = 0; i < 8; i++) begin
            hi = u64 ? (22'(sh_bnd[i]) << 14) : (22'(sh_bnd[i]) << 13);
            if (!found && hi != lo && pg >= lo && pg < hi) begin
                found = 1'b1;
                res[6]   = 1'b1;
                res[5:3] = 3'(i);
                res[2]   = sh_attr[4*i+3];
                res[1:0] = !en ? 2'd0 : ((dual && sh_attr[4*i+3]) ? 2'd2 : 2'd1);
            end
            lo = hi;
        end
        return res;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 4'd8)       sh_bnd[a[2:0]] = d[7:0];
        else if (a == 4'd8) sh_attr = d;
        else if (a == 4'd9) sh_mode = d;
    endtask

    task automatic decode(input string tag, input logic [21:0] pg);
        @(negedge clk);
        decode_go = 1'b1; page_in = pg;
        @(negedge clk);
        decode_go = 1'b0;
        chk({tag, " R10 valid"}, 32'(out_valid), 32'd1);
        chk({tag, " result"}, 32'({hit, row_idx, width_x4, ecc_mode}), 32'(model(pg, 1'b0)));
        chk({tag, " result fixed variant"},
            32'({hit_f, row_idx_f, width_x4_f, ecc_mode_f}), 32'(model(pg, 1'b1)));
    endtask

    task automatic load_bnd(input logic [7:0] b0, b1, b2, b3, b4, b5, b6, b7);
        wr(4'd0, 32'(b0)); wr(4'd1, 32'(b1)); wr(4'd2, 32'(b2)); wr(4'd3, 32'(b3));
        wr(4'd4, 32'(b4)); wr(4'd5, 32'(b5)); wr(4'd6, 32'(b6)); wr(4'd7, 32'(b7));
    endtask

    task automatic t_reset();
        chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
        decode("R1 decode after reset", 22'd0);
        chk("R1 no hit after reset", 32'({hit, row_idx}), 32'd0);
    endtask

    task automatic t_unit32();
        // 32 MiB unit, single channel, ECC on, row 2 x4
        wr(4'd9, 32'h0030_0000);
        wr(4'd8, 32'h0000_0800);
        load_bnd(8'd1, 8'd2, 8'd4, 8'd4, 8'd6, 8'd8, 8'd8, 8'd8);
        decode("R4 row0 first page", 22'd0);
        decode("R4 row0 last page", 22'd8191);
        decode("R4 row1 first page", 22'd8192);
        decode("R8 row2 x4 SECDED single channel R9", 22'd16384);
        chk("R8 row2 width", 32'(width_x4), 32'd1);
        chk("R9 single channel x4 gives SECDED", 32'(ecc_mode), 32'd1);
        decode("R4 row2 last page", 22'd32767);
        decode("R5 skip unpopulated row3", 22'd32768);
        chk("R5 row index after skip", 32'(row_idx), 32'd4);
        decode("R4 row5 last page", 22'd65535);
        decode("R7 page at total size", 22'd65536);
        chk("R7 miss flag", 32'({hit, row_idx}), 32'd0);
        decode("R7 top page", 22'h3F_FFFF);
    endtask

    task automatic t_unit64();
        wr(4'd9, 32'h0034_0000);
        decode("R3 64MiB unit row0", 22'd8192);
        chk("R3 64MiB page 8192 in row0", 32'({hit, row_idx}), 32'b1000);
        decode("R3 64MiB row1", 22'd16384);
        wr(4'd9, 32'h0038_0000);
        decode("R3 unit field value 2", 22'd20000);
    endtask

    task automatic t_ecc();
        wr(4'd9, 32'h0070_0000);
        decode("R9 dual x4 symbol", 22'd20000);
        chk("R9 dual x4 code", 32'(ecc_mode), 32'd2);
        decode("R9 dual x8 SECDED", 22'd100);
        chk("R9 dual x8 code", 32'(ecc_mode), 32'd1);
        wr(4'd9, 32'h0040_0000);
        decode("R9 ECC off", 22'd20000);
        chk("R9 ECC off code", 32'(ecc_mode), 32'd0);
        wr(4'd8, 32'hFFFF_FFFF);
        wr(4'd9, 32'h0010_0000);
        decode("R8 all x4 row4", 22'd40000);
    endtask

    task automatic t_overlap();
        wr(4'd9, 32'h0010_0000);
        load_bnd(8'd10, 8'd20, 8'd5, 8'd15, 8'd15, 8'd15, 8'd15, 8'd15);
        decode("R6 overlap rows1 and 3", 22'(12 * 8192));
        chk("R6 lowest index wins", 32'(row_idx), 32'd1);
        decode("R6 only row1", 22'(18 * 8192));
        decode("R7 beyond all ranges", 22'(25 * 8192));
    endtask

    task automatic t_ignore();
        load_bnd(8'd3, 8'd6, 8'd9, 8'd12, 8'd15, 8'd18, 8'd21, 8'd24);
        for (int a = 10; a < 16; a++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 4'(a); wr_data = 32'hFFFF_FFFF;
        end
        @(negedge clk);
        wr_en = 1'b0;
        decode("R2 unused address leaves state", 22'(24 * 8192));
        chk("R2 last boundary still 24", 32'(hit), 32'd0);
        decode("R2 row0 intact", 22'd100);
        wr(4'd0, 32'hABCD_0102);
        decode("R2 boundary takes low byte", 22'(2 * 8192));
        chk("R2 low byte boundary row", 32'({hit, row_idx}), 32'b1001);
    endtask

    task automatic t_timing();
        @(negedge clk);
        chk("R10 idle no valid", 32'(out_valid), 32'd0);
        decode_go = 1'b1; page_in = 22'd100;
        @(negedge clk);
        page_in = 22'(7 * 8192);
        chk("R10 back-to-back first", 32'({out_valid, hit, row_idx}), 32'b1_1_000);
        @(negedge clk);
        decode_go = 1'b0;
        chk("R10 back-to-back second", 32'({out_valid, hit, row_idx}), 32'b1_1_010);
        @(negedge clk);
        chk("R10 hold result", 32'({out_valid, hit, row_idx}), 32'b0_1_010);
        page_in = 22'd0;
        @(negedge clk);
        chk("R10 input change without strobe", 32'({hit, row_idx}), 32'b1_010);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) sh_bnd[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unit32();
        t_unit64();
        t_ecc();
        t_overlap();
        t_ignore();
        t_timing();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule